// File: doc/BRIEF.md
# Select-Synchronised SPI Slave Shift Engine

This block is the receive and transmit engine of an SPI slave. Its shift logic runs on the serial clock supplied by the external master, not on the system clock. On the system side it offers a transmit buffer with a write strobe, a receive buffer with a read strobe, a completion interrupt flag, an overflow flag and a configuration error flag. The configuration inputs are an enable, a 4-bit mode field, the clock idle level, the clock phase and the sample-point bit.

In select-controlled mode (mode field 4'b0100) the slave-select input decides whether the engine runs. While select is high, the bit counter is held at zero, any partial byte is thrown away and the serial output is released. Every byte is therefore aligned to the falling edge of select, which lets the slave recover after a stray clock edge. Clearing the enable has the same effect, and also clears the engine's transmit bookkeeping. Data moves most significant bit first.

The system side writes a byte to the transmit buffer while the bus is idle. That byte goes out once. A byte that starts without a new write echoes the byte received last. Each completed byte passes through a two-flop synchroniser into the system clock domain, where it fills the receive buffer and raises the interrupt flag.

Top module: `spi_sel_slave`

## Requirements
- R1: With cfg_mode = 4'b0100 and ss_n high, sdo_oe is 0 and the bit counter is held at zero. A byte cut short by raising ss_n is discarded, and the next full byte after ss_n falls is received intact.
- R2: With any cfg_mode value other than 4'b0100, ss_n has no effect. While enabled, sdo_oe is 1 and bytes are received and sent with ss_n high.
- R3: While cfg_en is 0, sdo_oe is 0 and the engine is reset: the partial byte, the pending transmit write and the last received byte (which reads as 0 afterwards) are all cleared.
- R4: Received bits are assembled MSB first. By the third rising clk edge after the eighth sampling edge, the byte is on rx_data and irq is 1.
- R5: A byte written with buf_wr while the bus is idle is sent MSB first. Its bit 7 is on sdo as soon as the engine is selected (for cfg_cke = 1).
- R6: Each buffer write is sent exactly once. A byte that starts with no new write sends the byte received last.
- R7: cfg_ckp is the sck idle level. With cfg_cke = 1, sdi is sampled on the edge leaving idle and sdo changes on the edge returning to idle. With cfg_cke = 0, sdo changes on the edge leaving idle and sdi is sampled on the return.
- R8: A byte that completes while rx_data is still unread (no buf_rd since the last completion) sets ovf and leaves rx_data unchanged.
- R9: A buf_rd pulse frees the receive buffer, so the next byte loads without overflow.
- R10: A flag_wr pulse clears irq if flag_wdata[0] is 0 and clears ovf if flag_wdata[1] is 0. A bit of 1 leaves its flag as it is. A completion in the same cycle wins over the clear.
- R11: cfg_err is 1 one clk edge after the configuration becomes enabled with cfg_cke = 1 and cfg_mode other than 4'b0100, or enabled with cfg_smp = 1. Otherwise it is 0.
- R12: After reset, irq, ovf, cfg_err and rx_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (system side; also resets the serial side) |
| cfg_en | input | 1 | Module enable; 0 holds the engine in reset |
| cfg_mode | input | 4 | Mode field; 4'b0100 selects select-controlled slave mode |
| cfg_ckp | input | 1 | Serial clock idle level |
| cfg_cke | input | 1 | Clock phase: 1 samples on the edge leaving idle |
| cfg_smp | input | 1 | Sample-point bit; must be 0 in slave mode |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_W | Transmit buffer write data |
| buf_rd | input | 1 | Receive buffer read strobe |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data: bit 0 irq, bit 1 ovf; 0 clears |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave select, active low |
| sdo | output | 1 | Serial data out, high impedance when released |
| sdo_oe | output | 1 | Output enable for sdo |
| rx_data | output | DATA_W | Receive buffer |
| irq | output | 1 | Byte completion flag |
| ovf | output | 1 | Receive overflow flag |
| cfg_err | output | 1 | Configuration error flag |

## Verification
Serial-side results arrive on the serial clock's schedule. sdo is settled half a serial period after the edge that launches it, and the bench reads it just before the sampling edge a master would use. System-side results need at most three clk edges after the last sampling edge, so the bench reads rx_data, irq and ovf only after at least four clk cycles have passed since that edge. cfg_err and the flag clears are registered and are checked one or two clk cycles after the input that causes them, on the falling half of clk.

// File: rtl/spi_sel_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the select-synchronised SPI slave.
package spi_sel_pkg;
    typedef logic [3:0] spi_mode_t;
    // Mode field value that enables select-controlled slave operation.
    localparam spi_mode_t MODE_SEL_SLAVE = 4'b0100;
    // Bit positions inside the flag write word.
    localparam int FLAG_IRQ_BIT = 0;
    localparam int FLAG_OVF_BIT = 1;
endpackage

// File: rtl/spi_sel_rx.sv
`timescale 1ns/1ps
// Receive half of the serial engine, clocked by the sampling edge.
// Assumes: samp_clk already has the polarity and phase folded in.
// eng_rst_n clears the bit counter asynchronously (deselect or disable).
// keep_rst_n clears only the completion toggle and the last byte.
module spi_sel_rx #(
    parameter int W = 8
) (
    input  logic         samp_clk,
    input  logic         eng_rst_n,
    input  logic         keep_rst_n,
    input  logic         sdi,
    output logic         done_tgl,
    output logic [W-1:0] rx_last
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] bit_cnt;
    logic [W-2:0]  rx_sr;
    logic          last_bit;

    assign last_bit = (bit_cnt == CW'(W - 1));

    // Shift in one bit per sampling edge and count bits within the byte.
    always_ff @(posedge samp_clk or negedge eng_rst_n) begin
        if (!eng_rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else begin
            rx_sr   <= {rx_sr[W-3:0], sdi};
            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        end
    end

    // On the eighth bit capture the whole byte and flag completion by toggling.
    always_ff @(posedge samp_clk or negedge keep_rst_n) begin
        if (!keep_rst_n) begin
            rx_last  <= '0;
            done_tgl <= 1'b0;
        end else if (last_bit) begin
            rx_last  <= {rx_sr, sdi};
            done_tgl <= ~done_tgl;
        end
    end
endmodule

// File: rtl/spi_sel_tx.sv
`timescale 1ns/1ps
// Transmit half of the serial engine, clocked by the launching edge.
// Assumes: tx_buf and wr_tgl change only while the serial clock is idle.
// A byte boundary loads the fresh buffer if one was written, otherwise the
// byte received last. lcnt counts launches within the byte; its wrap point
// depends on the clock phase, since phase 0 launches before each sample.
module spi_sel_tx #(
    parameter int W = 8
) (
    input  logic         launch_clk,
    input  logic         eng_rst_n,
    input  logic         keep_rst_n,
    input  logic         sel_hold,
    input  logic         cke,
    input  logic [W-1:0] tx_buf,
    input  logic         wr_tgl,
    input  logic [W-1:0] rx_last,
    output logic         sdo_bit
);
    localparam int LW = $clog2(W + 1);

    logic [LW-1:0] lcnt;
    logic [W-1:0]  tx_sr;
    logic          ack;
    logic          fresh;
    logic          start;
    logic [W-1:0]  load_val;

    assign fresh    = wr_tgl ^ ack;
    assign load_val = fresh ? tx_buf : rx_last;
    assign start    = (lcnt == '0) || (lcnt == LW'(W));
    assign sdo_bit  = (lcnt == '0) ? load_val[W-1] : tx_sr[W-1];

    // Load at a byte boundary, otherwise shift the next bit toward sdo.
    always_ff @(posedge launch_clk or negedge eng_rst_n) begin
        if (!eng_rst_n) begin
            lcnt  <= '0;
            tx_sr <= '0;
        end else begin
            if (start) tx_sr <= cke ? {load_val[W-2:0], 1'b0} : load_val;
            else       tx_sr <= {tx_sr[W-2:0], 1'b0};
            if (start)                           lcnt <= LW'(1);
            else if (cke && lcnt == LW'(W - 1))  lcnt <= '0;
            else                                 lcnt <= lcnt + 1'b1;
        end
    end

    // Mark a buffer write as used once its byte starts in an active engine.
    always_ff @(posedge launch_clk or negedge keep_rst_n) begin
        if (!keep_rst_n)
            ack <= 1'b0;
        else if (start && !sel_hold && fresh)
            ack <= wr_tgl;
    end
endmodule

// File: rtl/spi_sel_sys.sv
`timescale 1ns/1ps
// System-clock side: transmit buffer, completion synchroniser, receive
// buffer, flags and configuration check.
// Assumes: rx_last is stable for many clk cycles after done_tgl changes.
module spi_sel_sys
    import spi_sel_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  spi_mode_t    cfg_mode,
    input  logic         cfg_cke,
    input  logic         cfg_smp,
    input  logic         buf_wr,
    input  logic [W-1:0] buf_wdata,
    input  logic         buf_rd,
    input  logic         flag_wr,
    input  logic [1:0]   flag_wdata,
    input  logic         done_tgl,
    input  logic [W-1:0] rx_last,
    output logic [W-1:0] tx_buf,
    output logic         wr_tgl,
    output logic [W-1:0] rx_data,
    output logic         irq,
    output logic         ovf,
    output logic         cfg_err
);
    logic [2:0] sync_q;
    logic       evt;
    logic       full_q;

    assign evt = sync_q[1] ^ sync_q[2];

    // Two-flop synchroniser plus edge-detect stage for the completion toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en) sync_q <= '0;
        else                   sync_q <= {sync_q[1:0], done_tgl};
    end

    // Transmit buffer contents.
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_buf <= '0;
        else if (buf_wr) tx_buf <= buf_wdata;
    end

    // Write-announce toggle, cleared with the serial side when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en) wr_tgl <= 1'b0;
        else if (buf_wr)       wr_tgl <= ~wr_tgl;
    end

    // Receive buffer and its occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            full_q  <= 1'b0;
        end else if (evt && !full_q) begin
            rx_data <= rx_last;
            full_q  <= 1'b1;
        end else if (buf_rd) begin
            full_q  <= 1'b0;
        end
    end

    // Completion and overflow flags; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            ovf <= 1'b0;
        end else begin
            if (evt)                                       irq <= 1'b1;
            else if (flag_wr && !flag_wdata[FLAG_IRQ_BIT]) irq <= 1'b0;
            if (evt && full_q)                             ovf <= 1'b1;
            else if (flag_wr && !flag_wdata[FLAG_OVF_BIT]) ovf <= 1'b0;
        end
    end

    // Configuration error check.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= cfg_en && ((cfg_cke && cfg_mode != MODE_SEL_SLAVE) || cfg_smp);
    end

    // R4: a synchronised completion raises irq on the next edge.
    a_r4_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> irq);
    // R8: a completion into a full buffer sets ovf and keeps the data.
    a_r8_keep_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && full_q) |=> (ovf && $stable(rx_data)));
    // R10: writing zero to the irq bit without a completion clears irq.
    a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata[FLAG_IRQ_BIT] && !evt) |=> !irq);
    // R9: a read with no completion frees the buffer.
    a_r9_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !evt) |=> !full_q);
endmodule

// File: rtl/spi_sel_slave.sv
`timescale 1ns/1ps
// Top level of the select-synchronised SPI slave.
// Assumes: sck, sdi and ss_n are asynchronous to clk; configuration and
// buffer writes change only while the serial clock is idle.
// Builds the sampling clock from sck, polarity and phase, and derives the
// engine reset from enable and select.
module spi_sel_slave
    import spi_sel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [3:0]        cfg_mode,
    input  logic              cfg_ckp,
    input  logic              cfg_cke,
    input  logic              cfg_smp,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              flag_wr,
    input  logic [1:0]        flag_wdata,
    input  logic              sck,
    input  logic              sdi,
    input  logic              ss_n,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq,
    output logic              ovf,
    output logic              cfg_err
);
    logic              sel_hold;
    logic              keep_rst_n;
    logic              eng_rst_n;
    logic              samp_clk;
    logic              launch_clk;
    logic              sdo_bit;
    logic              done_tgl;
    logic              wr_tgl;
    logic [DATA_W-1:0] rx_last;
    logic [DATA_W-1:0] tx_buf;

    assign sel_hold   = (cfg_mode == MODE_SEL_SLAVE) && ss_n;
    assign keep_rst_n = rst_n && cfg_en;
    assign eng_rst_n  = keep_rst_n && !sel_hold;
    assign samp_clk   = sck ^ cfg_ckp ^ ~cfg_cke;
    assign launch_clk = ~samp_clk;
    assign sdo_oe     = cfg_en && !sel_hold;
    assign sdo        = sdo_oe ? sdo_bit : 1'bz;

    spi_sel_rx #(.W(DATA_W)) u_rx (
        .samp_clk   (samp_clk),
        .eng_rst_n  (eng_rst_n),
        .keep_rst_n (keep_rst_n),
        .sdi        (sdi),
        .done_tgl   (done_tgl),
        .rx_last    (rx_last)
    );

    spi_sel_tx #(.W(DATA_W)) u_tx (
        .launch_clk (launch_clk),
        .eng_rst_n  (eng_rst_n),
        .keep_rst_n (keep_rst_n),
        .sel_hold   (sel_hold),
        .cke        (cfg_cke),
        .tx_buf     (tx_buf),
        .wr_tgl     (wr_tgl),
        .rx_last    (rx_last),
        .sdo_bit    (sdo_bit)
    );

    spi_sel_sys #(.W(DATA_W)) u_sys (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_mode   (cfg_mode),
        .cfg_cke    (cfg_cke),
        .cfg_smp    (cfg_smp),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .buf_rd     (buf_rd),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .done_tgl   (done_tgl),
        .rx_last    (rx_last),
        .tx_buf     (tx_buf),
        .wr_tgl     (wr_tgl),
        .rx_data    (rx_data),
        .irq        (irq),
        .ovf        (ovf),
        .cfg_err    (cfg_err)
    );
endmodule

// File: tb/spi_sel_slave_tb.sv
`timescale 1ns/1ps
module spi_sel_slave_tb;
    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic [3:0] cfg_mode = 4'b0100;
    logic       cfg_ckp = 1'b0;
    logic       cfg_cke = 1'b1;
    logic       cfg_smp = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic       buf_rd = 1'b0;
    logic       flag_wr = 1'b0;
    logic [1:0] flag_wdata = '0;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       ss_n = 1'b1;
    logic       sdo, sdo_oe, irq, ovf, cfg_err;
    logic [7:0] rx_data;

    int errs = 0;
    int checks = 0;
    logic [7:0] last_rx = 8'h00;
    logic [7:0] miso;

    always #2.5 clk = ~clk;

    spi_sel_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_ckp(cfg_ckp), .cfg_cke(cfg_cke), .cfg_smp(cfg_smp),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .sck(sck), .sdi(sdi),
        .ss_n(ss_n), .sdo(sdo), .sdo_oe(sdo_oe), .rx_data(rx_data),
        .irq(irq), .ovf(ovf), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_buf(input logic [7:0] b);
        buf_wdata = b; buf_wr = 1'b1; wait_clks(1); buf_wr = 1'b0;
    endtask

    task automatic rd_buf();
        buf_rd = 1'b1; wait_clks(1); buf_rd = 1'b0;
    endtask

    task automatic wr_flags(input logic [1:0] v);
        flag_wdata = v; flag_wr = 1'b1; wait_clks(1); flag_wr = 1'b0;
    endtask

    // Master side: shifts nbits of mosi MSB first, captures sdo before each sampling edge.
    task automatic shift_bits(input logic [7:0] mosi, input int nbits, output logic [7:0] got);
        got = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (cfg_cke) begin
                sdi = mosi[i]; #HALF; got[i] = sdo;
                sck = ~cfg_ckp; #HALF; sck = cfg_ckp;
            end else begin
                sck = ~cfg_ckp; sdi = mosi[i]; #HALF; got[i] = sdo;
                sck = cfg_ckp; #HALF;
            end
        end
        #HALF;
    endtask

    function automatic logic [7:0] exp_miso(input bit wrote, input logic [7:0] tx, input logic [7:0] last);
        return wrote ? tx : last;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] tx, mosi;
        bit wrote;
        void'($urandom(32'h5EED_0721));
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        // R12 reset state
        chk(irq == 0, "R12 irq", irq, 0);
        chk(ovf == 0, "R12 ovf", ovf, 0);
        chk(cfg_err == 0, "R12 cfg_err", cfg_err, 0);
        chk(rx_data == 0, "R12 rx_data", rx_data, 0);
        chk(sdo_oe == 0, "R3 sdo_oe disabled", sdo_oe, 0);

        cfg_en = 1'b1; wait_clks(2);
        chk(sdo_oe == 0, "R1 sdo_oe deselected", sdo_oe, 0);
        chk(cfg_err == 0, "R11 valid config", cfg_err, 0);

        // R5 fresh buffer, R4 receive
        wr_buf(8'hA5);
        ss_n = 1'b0; #HALF;
        chk(sdo_oe == 1, "R1 sdo_oe selected", sdo_oe, 1);
        chk(sdo == 1'b1, "R5 first bit on select", sdo, 1);
        shift_bits(8'h3C, 8, miso);
        ss_n = 1'b1; wait_clks(2);
        chk(miso == 8'hA5, "R5 transmit", miso, 8'hA5);
        chk(rx_data == 8'h3C, "R4 rx_data", rx_data, 8'h3C);
        chk(irq == 1, "R4 irq", irq, 1);
        chk(ovf == 0, "R8 no ovf", ovf, 0);
        last_rx = 8'h3C;

        // R6 echo, R8 overflow
        ss_n = 1'b0; #HALF;
        shift_bits(8'hC3, 8, miso);
        ss_n = 1'b1; wait_clks(2);
        chk(miso == last_rx, "R6 echo last byte", miso, last_rx);
        chk(ovf == 1, "R8 ovf set", ovf, 1);
        chk(rx_data == 8'h3C, "R8 rx_data kept", rx_data, 8'h3C);
        last_rx = 8'hC3;

        // R10 selective clears
        wr_flags(2'b10); #2;
        chk(irq == 0, "R10 irq cleared", irq, 0);
        chk(ovf == 1, "R10 ovf kept", ovf, 1);
        wr_flags(2'b01); #2;
        chk(ovf == 0, "R10 ovf cleared", ovf, 0);
        rd_buf();

        // R1 abort by deselect mid-byte
        ss_n = 1'b0; #HALF;
        shift_bits(8'hFF, 3, miso);
        ss_n = 1'b1; #HALF;
        chk(sdo_oe == 0, "R1 released on abort", sdo_oe, 0);
        ss_n = 1'b0; #HALF;
        shift_bits(8'h81, 8, miso);
        ss_n = 1'b1; wait_clks(2);
        chk(rx_data == 8'h81, "R1 realigned byte", rx_data, 8'h81);
        chk(ovf == 0, "R9 no ovf after read", ovf, 0);
        chk(miso == last_rx, "R6 echo after abort", miso, last_rx);
        last_rx = 8'h81;
        rd_buf(); wr_flags(2'b00);

        // R3 abort by disable mid-byte
        ss_n = 1'b0; #HALF;
        shift_bits(8'hF0, 5, miso);
        cfg_en = 1'b0; #HALF;
        chk(sdo_oe == 0, "R3 released when disabled", sdo_oe, 0);
        wait_clks(3);
        cfg_en = 1'b1; wait_clks(3);
        shift_bits(8'h42, 8, miso);
        ss_n = 1'b1; wait_clks(2);
        chk(rx_data == 8'h42, "R3 realigned after disable", rx_data, 8'h42);
        chk(miso == 8'h00, "R3 last byte cleared", miso, 0);
        last_rx = 8'h42;
        rd_buf(); wr_flags(2'b00);

        // R2 select ignored in another mode (phase 0)
        cfg_cke = 1'b0; wait_clks(1);
        cfg_mode = 4'b0101; wait_clks(2);
        chk(sdo_oe == 1, "R2 driven with ss_n high", sdo_oe, 1);
        wr_buf(8'h96);
        shift_bits(8'h69, 8, miso);
        wait_clks(2);
        chk(miso == 8'h96, "R2 R7 transmit phase 0", miso, 8'h96);
        chk(rx_data == 8'h69, "R2 receive with ss_n high", rx_data, 8'h69);
        last_rx = 8'h69;
        rd_buf(); wr_flags(2'b00);
        cfg_mode = 4'b0100; wait_clks(1);

        // R11 configuration error
        cfg_cke = 1'b1; wait_clks(1);
        cfg_mode = 4'b0101; wait_clks(2);
        chk(cfg_err == 1, "R11 phase 1 without select mode", cfg_err, 1);
        cfg_mode = 4'b0100; wait_clks(2);
        chk(cfg_err == 0, "R11 phase 1 with select mode", cfg_err, 0);
        cfg_smp = 1'b1; wait_clks(2);
        chk(cfg_err == 1, "R11 sample bit set", cfg_err, 1);
        cfg_smp = 1'b0; wait_clks(2);

        // R7 random polarity, phase, data and write pattern
        for (int it = 0; it < 32; it++) begin
            cfg_ckp = 1'($urandom % 2);
            cfg_cke = 1'($urandom % 2);
            sck = cfg_ckp;
            wait_clks(2);
            wrote = 1'($urandom % 2);
            tx = 8'($urandom);
            mosi = 8'($urandom);
            if (wrote) wr_buf(tx);
            ss_n = 1'b0; #HALF;
            shift_bits(mosi, 8, miso);
            ss_n = 1'b1; wait_clks(2);
            chk(miso == exp_miso(wrote, tx, last_rx), "R7 R6 random transmit", miso, exp_miso(wrote, tx, last_rx));
            chk(rx_data == mosi, "R7 R4 random receive", rx_data, mosi);
            chk(irq == 1 && ovf == 0, "R4 R9 flags", {irq, ovf}, 2'b10);
            last_rx = mosi;
            rd_buf(); wr_flags(2'b00);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule